// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block holds instructions that are ready to run. Each one carries a sequence number, an operation class and a small payload. It keeps one pool of entries for each class, so that a class maps straight onto its own functional unit. Every cycle it finds the oldest entry in each pool and then arbitrates across those class heads. It issues up to `IW` instructions per cycle, globally oldest first. A smaller sequence number always means an older instruction.

Each class has a functional-unit-available bit. A class whose unit is busy is passed over, and the next-oldest class head takes its turn in the same cycle. Each class also has a stall counter that records the cycles its ready work waited on a busy unit. A flush input with a sequence number drops every younger entry from all pools in a single cycle. Issue fields for slot s are placed at bits `[s*W +: W]` of each output vector.

Top module: `iss_select_top`

## Requirements
- R1: After reset, every pool is empty, no slot is valid, all stall counters read zero and all `pool_full` bits are low.
- R2: Slot 0 carries the entry with the smallest sequence number among all pooled entries whose class has its `fu_avail` bit high.
- R3: Within one cycle, the valid slots hold distinct entries, with strictly increasing sequence numbers from slot 0 upward.
- R4: Each cycle, the number of valid slots equals the smaller of `IW` and the number of eligible entries. The slots fill from slot 0 with no gaps.
- R5: A class whose `fu_avail` bit is low issues nothing. Other classes still issue in that cycle, including entries younger than the blocked ones.
- R6: Each class's stall counter rises by one on every non-flush cycle in which its pool is non-empty and its `fu_avail` bit is low. It holds at all ones (255 with defaults).
- R7: An issued entry leaves its pool at the clock edge. The class's next-oldest entry becomes its candidate in the following cycle.
- R8: While `flush_valid` is high, no slot is valid. Every entry with a sequence number greater than `flush_seq` is removed at the edge. An insertion in that same cycle is kept only if its sequence number is not greater than `flush_seq`.
- R9: `pool_full[c]` is high when pool c holds `DEPTH` entries. An insertion aimed at a pool that is full at the start of the cycle is dropped.
- R10: An insertion with `ins_cls` = c (0 to NC-1) enters pool c and becomes eligible for issue in the next cycle, carrying its payload with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert a ready instruction this cycle |
| ins_seq | input | SEQ_W | Sequence number of the insertion |
| ins_cls | input | CLS_W | Operation class of the insertion |
| ins_pay | input | PAY_W | Payload of the insertion |
| fu_avail | input | NC | Per-class functional unit can accept work |
| flush_valid | input | 1 | Flush entries younger than `flush_seq` |
| flush_seq | input | SEQ_W | Flush boundary sequence number |
| iss_valid | output | IW | Per-slot issue valid, slot 0 oldest |
| iss_cls | output | IW*CLS_W | Per-slot class |
| iss_seq | output | IW*SEQ_W | Per-slot sequence number |
| iss_pay | output | IW*PAY_W | Per-slot payload |
| pool_full | output | NC | Per-class pool full |
| busy_cnt | output | NC*CNT_W | Per-class stall counters |

## Verification
A wrong head inside a pool, or a wrong cross-class comparison, shows up in the same cycle as an out-of-age sequence number on a slot. The bench compares every slot against its own age-sorted list on every cycle.

A lost entry or a stuck entry shows up within a cycle or two. A lost entry leaves an expected sequence number missing once the pools drain. A stuck entry repeats a sequence number that should already have gone.

A flush or stall-counter fault shows at the ports on the cycle right after the edge. It appears as a surviving young entry on a slot or as a counter value off by one.

// File: rtl/iss_sel_pkg.sv
package iss_sel_pkg;
  // Age rule: the smaller sequence number is the older instruction.
  function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b);
    return a < b;
  endfunction

  // Saturating one-step increment toward maxv.
  function automatic logic [31:0] sat_step(input logic [31:0] v, input logic [31:0] maxv);
    return (v >= maxv) ? maxv : v + 32'd1;
  endfunction
endpackage

// File: rtl/iss_pool.sv
module iss_pool #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [PAY_W-1:0] ins_pay,
  input  logic [DEPTH-1:0] take,
  input  logic             flush_en,
  input  logic [SEQ_W-1:0] flush_seq,
  output logic [DEPTH-1:0] vld,
  output logic [SEQ_W-1:0] seq [DEPTH],
  output logic [PAY_W-1:0] pay [DEPTH],
  output logic             full
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0] free_idx;   // lowest empty slot
  logic [DEPTH-1:0] kill;       // entries removed by flush
  logic             wr_ok;      // insertion actually written

  assign full  = &vld;
  assign wr_ok = ins_en && !full;

  always_comb begin
    free_idx = '0;
    for (int e = DEPTH - 1; e >= 0; e--)
      if (!vld[e]) free_idx = IDX_W'(e);
  end

  always_comb
    for (int e = 0; e < DEPTH; e++)
      kill[e] = flush_en && vld[e] && (seq[e] > flush_seq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (take[e] || kill[e]) vld[e] <= 1'b0;
        if (wr_ok && free_idx == IDX_W'(e)) vld[e] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++)
      if (wr_ok && free_idx == IDX_W'(e)) begin
        seq[e] <= ins_seq;
        pay[e] <= ins_pay;
      end
  end

  // R7: the selector only removes live entries.
  a_r7_take_live: assert property (@(posedge clk) disable iff (!rst_n)
    (take & ~vld) == '0);
  // R9: an insertion into a full, otherwise idle pool changes nothing.
  a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && ins_en && take == '0 && !flush_en) |=> $stable(vld));
  // R8: flushed entries are gone after the edge.
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (kill != '0) |=> ((vld & $past(kill)) == '0));
endmodule

// File: rtl/iss_age_pick.sv
module iss_age_pick
  import iss_sel_pkg::*;
#(
  parameter int NC    = 4,
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int IW    = 2,
  parameter int CLS_W = 2,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] vld   [NC],
  input  logic [SEQ_W-1:0] seq   [NC][DEPTH],
  input  logic [NC-1:0]    avail,
  input  logic             block,
  output logic             slot_vld [IW],
  output logic [CLS_W-1:0] slot_cls [IW],
  output logic [SEQ_W-1:0] slot_seq [IW],
  output logic [IDX_W-1:0] slot_ent [IW],
  output logic [DEPTH-1:0] take  [NC]
);
  always_comb begin
    logic [DEPTH-1:0] used [NC];
    logic             hv   [NC];
    logic [IDX_W-1:0] hidx [NC];
    logic [SEQ_W-1:0] hseq [NC];
    logic             bv;
    logic [CLS_W-1:0] bc;
    logic [SEQ_W-1:0] bs;
    logic [IDX_W-1:0] bi;
    for (int c = 0; c < NC; c++) used[c] = '0;
    for (int s = 0; s < IW; s++) begin
      // Stage 1: oldest remaining entry in each class pool.
      for (int c = 0; c < NC; c++) begin
        hv[c] = 1'b0; hidx[c] = '0; hseq[c] = '0;
        for (int e = 0; e < DEPTH; e++)
          if (vld[c][e] && !used[c][e] &&
              (!hv[c] || seq_older(32'(seq[c][e]), 32'(hseq[c])))) begin
            hv[c] = 1'b1; hidx[c] = IDX_W'(e); hseq[c] = seq[c][e];
          end
      end
      // Stage 2: age arbitration across heads of classes with a free unit.
      bv = 1'b0; bc = '0; bs = '0; bi = '0;
      for (int c = 0; c < NC; c++)
        if (!block && avail[c] && hv[c] &&
            (!bv || seq_older(32'(hseq[c]), 32'(bs)))) begin
          bv = 1'b1; bc = CLS_W'(c); bs = hseq[c]; bi = hidx[c];
        end
      slot_vld[s] = bv;
      slot_cls[s] = bc;
      slot_seq[s] = bs;
      slot_ent[s] = bi;
      if (bv) used[bc][bi] = 1'b1;
    end
    for (int c = 0; c < NC; c++) take[c] = used[c];
  end

  // R8: no issue while a flush is applied.
  a_r8_quiet_flush: assert property (@(posedge clk) disable iff (!rst_n)
    block |-> !slot_vld[0]);

  for (genvar s = 0; s < IW; s++) begin : g_slot_chk
    // R5: a slot never carries a class whose unit is busy.
    a_r5_unit_free: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld[s] |-> avail[slot_cls[s]]);
    if (s > 0) begin : g_pair
      // R4: slots are packed from slot 0.
      a_r4_packed_slots: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld[s] |-> slot_vld[s-1]);
      // R3: later slots are strictly younger.
      a_r3_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld[s] |-> (slot_seq[s-1] < slot_seq[s]));
    end
  end
endmodule

// File: rtl/iss_busy_ctr.sv
module iss_busy_ctr
  import iss_sel_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (inc) cnt <= CNT_W'(sat_step(32'(cnt), 32'(CNT_MAX)));
  end

  // R6: the counter only ever moves up by one.
  a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == $past(cnt) + CNT_W'(1)));
  // R6: once saturated it stays there.
  a_r6_hold_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/iss_select_top.sv
module iss_select_top #(
  parameter int NC    = 4,
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int PAY_W = 8,
  parameter int IW    = 2,
  parameter int CNT_W = 8,
  localparam int CLS_W = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ins_valid,
  input  logic [SEQ_W-1:0]    ins_seq,
  input  logic [CLS_W-1:0]    ins_cls,
  input  logic [PAY_W-1:0]    ins_pay,
  input  logic [NC-1:0]       fu_avail,
  input  logic                flush_valid,
  input  logic [SEQ_W-1:0]    flush_seq,
  output logic [IW-1:0]       iss_valid,
  output logic [IW*CLS_W-1:0] iss_cls,
  output logic [IW*SEQ_W-1:0] iss_seq,
  output logic [IW*PAY_W-1:0] iss_pay,
  output logic [NC-1:0]       pool_full,
  output logic [NC*CNT_W-1:0] busy_cnt
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] pool_vld [NC];
  logic [SEQ_W-1:0] seq_all  [NC][DEPTH];
  logic [PAY_W-1:0] pay_all  [NC][DEPTH];
  logic [DEPTH-1:0] take_all [NC];
  logic [NC-1:0]    ins_hit;    // insertion routed to class c
  logic [NC-1:0]    busy_inc;   // class c stalled on its unit
  logic             ins_young;  // insertion younger than flush point

  logic             slot_vld [IW];
  logic [CLS_W-1:0] slot_cls [IW];
  logic [SEQ_W-1:0] slot_seq [IW];
  logic [IDX_W-1:0] slot_ent [IW];

  assign ins_young = flush_valid && (ins_seq > flush_seq);

  for (genvar c = 0; c < NC; c++) begin : g_cls
    assign ins_hit[c]  = ins_valid && !ins_young && (ins_cls == CLS_W'(c));
    assign busy_inc[c] = !flush_valid && (|pool_vld[c]) && !fu_avail[c];

    iss_pool #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .PAY_W(PAY_W)) u_pool (
      .clk(clk), .rst_n(rst_n),
      .ins_en(ins_hit[c]), .ins_seq(ins_seq), .ins_pay(ins_pay),
      .take(take_all[c]), .flush_en(flush_valid), .flush_seq(flush_seq),
      .vld(pool_vld[c]), .seq(seq_all[c]), .pay(pay_all[c]),
      .full(pool_full[c])
    );

    iss_busy_ctr #(.CNT_W(CNT_W)) u_busy (
      .clk(clk), .rst_n(rst_n), .inc(busy_inc[c]),
      .cnt(busy_cnt[c*CNT_W +: CNT_W])
    );
  end

  iss_age_pick #(
    .NC(NC), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .IW(IW),
    .CLS_W(CLS_W), .IDX_W(IDX_W)
  ) u_pick (
    .clk(clk), .rst_n(rst_n),
    .vld(pool_vld), .seq(seq_all), .avail(fu_avail), .block(flush_valid),
    .slot_vld(slot_vld), .slot_cls(slot_cls), .slot_seq(slot_seq),
    .slot_ent(slot_ent), .take(take_all)
  );

  for (genvar s = 0; s < IW; s++) begin : g_out
    assign iss_valid[s]                 = slot_vld[s];
    assign iss_cls[s*CLS_W +: CLS_W]    = slot_cls[s];
    assign iss_seq[s*SEQ_W +: SEQ_W]    = slot_seq[s];
    assign iss_pay[s*PAY_W +: PAY_W]    = pay_all[slot_cls[s]][slot_ent[s]];
  end
endmodule

// File: tb/tb_iss_select_top.sv
module tb_iss_select_top;
  localparam int NC = 4, DEPTH = 8, SEQ_W = 16, PAY_W = 8, IW = 2, CNT_W = 8;
  localparam int CLS_W = 2;
  localparam int MSZ = NC * DEPTH;
  localparam int SAT = 255;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, flush_valid = 0;
  logic [SEQ_W-1:0] ins_seq = '0, flush_seq = '0;
  logic [CLS_W-1:0] ins_cls = '0;
  logic [PAY_W-1:0] ins_pay = '0;
  logic [NC-1:0] fu_avail = '0;
  logic [IW-1:0] iss_valid;
  logic [IW*CLS_W-1:0] iss_cls;
  logic [IW*SEQ_W-1:0] iss_seq;
  logic [IW*PAY_W-1:0] iss_pay;
  logic [NC-1:0] pool_full;
  logic [NC*CNT_W-1:0] busy_cnt;

  iss_select_top #(.NC(NC), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .PAY_W(PAY_W),
                   .IW(IW), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_seq(ins_seq),
    .ins_cls(ins_cls), .ins_pay(ins_pay), .fu_avail(fu_avail),
    .flush_valid(flush_valid), .flush_seq(flush_seq), .iss_valid(iss_valid),
    .iss_cls(iss_cls), .iss_seq(iss_seq), .iss_pay(iss_pay),
    .pool_full(pool_full), .busy_cnt(busy_cnt));

  always #10 clk = ~clk;  // 50 MHz

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  bit mv [MSZ];
  int ms [MSZ];
  int mc [MSZ];
  int busy_exp [NC];

  function automatic int pay_of(int s, int c);
    return ((s * 3) ^ (c * 32)) & 255;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(bit iv, int s, int c, bit [NC-1:0] av, bit fv, int fs, string tag);
    int cnt [NC];
    int pick [IW];
    bit pv [IW];
    bit used [MSZ];
    int a, e;
    @(negedge clk);
    ins_valid = iv; ins_seq = SEQ_W'(s); ins_cls = CLS_W'(c);
    ins_pay = PAY_W'(pay_of(s, c)); fu_avail = av;
    flush_valid = fv; flush_seq = SEQ_W'(fs);
    #2;
    for (int k = 0; k < NC; k++) cnt[k] = 0;
    for (int i = 0; i < MSZ; i++) begin
      used[i] = 0;
      if (mv[i]) cnt[mc[i]]++;
    end
    for (int k = 0; k < NC; k++) begin
      chk(pool_full[k] == (cnt[k] == DEPTH), "R9 pool_full", int'(pool_full[k]), int'(cnt[k] == DEPTH));
      chk(int'(busy_cnt[k*CNT_W +: CNT_W]) == busy_exp[k], "R6 busy_cnt",
          int'(busy_cnt[k*CNT_W +: CNT_W]), busy_exp[k]);
    end
    // Expected slots: the IW oldest entries over classes with a free unit.
    for (int sl = 0; sl < IW; sl++) begin
      pv[sl] = 0; pick[sl] = 0;
      if (!fv)
        for (int i = 0; i < MSZ; i++)
          if (mv[i] && !used[i] && av[mc[i]] && (!pv[sl] || ms[i] < ms[pick[sl]])) begin
            pv[sl] = 1; pick[sl] = i;
          end
      if (pv[sl]) used[pick[sl]] = 1;
      a = iss_valid[sl] ? ((1 << 20) | (int'(iss_cls[sl*CLS_W +: CLS_W]) << 16)
                           | int'(iss_seq[sl*SEQ_W +: SEQ_W])) : 0;
      e = pv[sl] ? ((1 << 20) | (mc[pick[sl]] << 16) | ms[pick[sl]]) : 0;
      chk(a == e, tag, a, e);
      if (pv[sl])
        chk(int'(iss_pay[sl*PAY_W +: PAY_W]) == pay_of(ms[pick[sl]], mc[pick[sl]]),
            "R10 payload", int'(iss_pay[sl*PAY_W +: PAY_W]), pay_of(ms[pick[sl]], mc[pick[sl]]));
    end
    // Model update for the coming edge.
    for (int k = 0; k < NC; k++)
      if (!fv && cnt[k] > 0 && !av[k] && busy_exp[k] < SAT) busy_exp[k]++;
    for (int i = 0; i < MSZ; i++) begin
      if (used[i]) mv[i] = 0;
      if (fv && mv[i] && ms[i] > fs) mv[i] = 0;
    end
    if (iv && !(fv && s > fs) && cnt[c] < DEPTH)
      for (int i = 0; i < MSZ; i++)
        if (!mv[i]) begin
          mv[i] = 1; ms[i] = s; mc[i] = c;
          break;
        end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    for (int i = 0; i < MSZ; i++) begin mv[i] = 0; ms[i] = 0; mc[i] = 0; end
    for (int k = 0; k < NC; k++) busy_exp[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    chk(iss_valid == '0, "R1 iss_valid", int'(iss_valid), 0);
    chk(busy_cnt == '0, "R1 busy_cnt", int'(busy_cnt), 0);
    chk(pool_full == '0, "R1 pool_full", int'(pool_full), 0);

    // Sweep all unit-availability masks over scrambled-age fills.
    for (int r = 0; r < 16; r++) begin
      base = 16 + r * 16;
      step(0, 0, 0, '0, 1, 0, "R8 clear");
      for (int i = 0; i < 8; i++)
        step(1, base + ((i * 5) % 8), (i * 3 + r) % NC, '0, 0, 0, "R10 fill");
      step(0, 0, 0, 4'(r), 0, 0, "R5 masked issue");
      step(0, 0, 0, 4'(r), 0, 0, "R7 next head");
      step(0, 0, 0, 4'hF, 0, 0, "R2 oldest");
      step(0, 0, 0, 4'hF, 0, 0, "R3 order");
      step(0, 0, 0, 4'hF, 0, 0, "R4 count");
    end

    // Full pool: ninth insertion into class 2 is dropped.
    step(0, 0, 0, '0, 1, 0, "R8 clear");
    for (int i = 0; i < 9; i++) step(1, 1000 + i, 2, '0, 0, 0, "R9 fill");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 4'hF, 0, 0, "R9 drain");

    // Partial flush with same-cycle insertions on both sides of the boundary.
    for (int i = 0; i < 6; i++) step(1, 2000 + i, i % NC, '0, 0, 0, "R10 fill");
    step(1, 2010, 1, '0, 1, 2002, "R8 young insert");
    step(1, 1990, 3, '0, 1, 2002, "R8 old insert");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 4'hF, 0, 0, "R8 survivors");

    // Saturation of one stall counter.
    step(1, 3000, 3, 4'b0111, 0, 0, "R6 seed");
    for (int i = 0; i < 300; i++) step(0, 0, 0, 4'b0111, 0, 0, "R6 saturate");
    @(negedge clk); #2;
    chk(int'(busy_cnt[3*CNT_W +: CNT_W]) == SAT, "R6 saturated",
        int'(busy_cnt[3*CNT_W +: CNT_W]), SAT);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule